// File: doc/BRIEF.md
# Three-Channel Compare-Match Timer

The block is a timer peripheral with three identical 16-bit up-counters. Each channel counts a prescaled version of the bus clock and compares its counter with a 16-bit compare value. When the two are equal on a count tick, the channel does three things. It sets a match flag. It can drive its output pin low, drive it high or toggle it. It can return the counter to zero, which makes a periodic tick source with a period of compare value plus one counts. A counter that wraps from all ones to zero sets a separate overflow flag. Each flag raises the channel's interrupt line when its enable bit is set.

Software reaches the block through a single-cycle bus with byte and halfword registers. A run register at address 0x280 holds one start bit per channel, so all channels can be started or stopped with one write. Each channel has its own 16-byte window: channel 0 at 0x300, channel 1 at 0x380 and channel 2 at 0x000. The status flags use a read-then-write-zero clearing protocol. A flag cannot be lost to a blind write, and it cannot be cleared by accident while a new event is arriving.

Top module: `cmt_unit`

## Requirements
- R1: After reset every register reads 0, every pin is low and every interrupt line is low.
- R2: Bit n of the run register (address 0x280, bits 2:0) enables channel n only. While the bit is 0, that channel's counter holds its value and the other channels are unaffected.
- R3: Control bits 2:0 select the count rate. Codes 0, 1, 2 and 3 advance the counter once every 1, 4, 16 and 64 bus clocks. Codes 4 to 7 stop counting.
- R4: With control bits 7:5 equal to 1, a count tick that finds the counter equal to the compare value sets status bit 0 and loads 0 into the counter. The counter therefore runs 0 up to the compare value and repeats.
- R5: With control bits 7:5 at any other code, the counter runs freely. A tick at 0xFFFF wraps it to 0 and sets status bit 4. A return to zero caused by a compare match does not set bit 4.
- R6: A mode register (offset 1) value whose bits 3:0 are non-zero holds the counter.
- R7: Writing 0 to a status bit clears it only if the status register was read with that bit at 1 since the flag was last set. Writing 1 leaves it unchanged.
- R8: Output-control bits 3:0 set the pin. A write of code 1, 2 or 3 drives the pin to 0 at once, and code 5, 6 or 7 drives it to 1. On a match, codes 1 and 5 clear the pin, 2 and 6 set it, and 3 and 7 toggle it. Code 0 leaves it unchanged. Bits 7:4 do not affect the pin.
- R9: A channel's interrupt line is high while status bit 0 is set with enable bit 0 (offset 4), or status bit 4 is set with enable bit 4.
- R10: Channel registers sit at byte offsets 0 control, 1 mode, 2 output control, 4 interrupt enable, 5 status, 6 counter (16-bit) and 8 compare (16-bit). Each is written and read back at those offsets. Unmapped offsets read 0.
- R11: Control bits 4:3, the edge selection, are stored and read back but do not change the count rate from the internal prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 10 | Byte address within the unit |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; arms status clearing |
| bus_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| bus_rdata | output | 16 | Read data for the addressed register, valid in the strobe cycle |
| tmr_out | output | 3 | Compare-output pin per channel |
| tmr_irq | output | 3 | Interrupt request per channel |

## Verification
The counting path is tested with clear-on-match at a small compare value, over windows of 7 and 11 ticks. These windows separate one match from two, and an off-by-one period from the correct compare-plus-one period. The prescaler is measured over windows that are whole multiples of its divide ratio. The result then depends only on the rate and not on the prescaler phase. Free-running counts started just below 0xFFFF are run once with no clearing and once with clear-on-0xFFFF, which separates a true wrap from a match-driven return to zero. The status protocol is tried with a blind zero write, a write of ones after a read, and a proper read-then-zero sequence. Each pin code is written with the channel stopped to isolate the load level from the match action.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int unsigned BUS_AW = 10;
  localparam int unsigned BUS_DW = 16;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned OFS_W  = 4;

  localparam logic [BUS_AW-1:0] START_ADDR = 10'h280;

  localparam logic [OFS_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [OFS_W-1:0] OFS_MODE = 4'h1;
  localparam logic [OFS_W-1:0] OFS_OUTC = 4'h2;
  localparam logic [OFS_W-1:0] OFS_IEN  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_STS  = 4'h5;
  localparam logic [OFS_W-1:0] OFS_CNT  = 4'h6;
  localparam logic [OFS_W-1:0] OFS_CMP  = 4'h8;

  localparam int unsigned FLG_MATCH_BIT = 0;
  localparam int unsigned FLG_WRAP_BIT  = 4;

  localparam logic [2:0] CLR_ON_MATCH = 3'd1;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;

  // action taken on a compare match for a 4-bit output-control code
  function automatic pin_act_e outc_action(input logic [3:0] code);
    if (code[3] || code[1:0] == 2'b00) return PIN_KEEP;
    return pin_act_e'(code[1:0]);
  endfunction

  // {load now, level to load} for a freshly written output-control code
  function automatic logic [1:0] outc_init(input logic [3:0] code);
    return {~code[3] & (code[1:0] != 2'b00), code[2]};
  endfunction

  function automatic logic [BUS_AW-1:0] chan_base(input int unsigned idx);
    if (idx == 0) return 10'h300;
    if (idx == 1) return 10'h380;
    return 10'h000;
  endfunction

endpackage

// File: rtl/cmt_rst_sync.sv
module cmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cmt_prescale.sv
module cmt_prescale #(
  parameter int unsigned NUM_TAPS = 4,
  parameter int unsigned TAP_STEP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_TAPS-1:0] tick
);
  localparam int unsigned DIV_W = TAP_STEP * (NUM_TAPS - 1);

  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick[0] = 1'b1;
  for (genvar t = 1; t < NUM_TAPS; t++) begin : g_tap
    assign tick[t] = &div_q[TAP_STEP*t-1:0];
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W    = BUS_DW,
  parameter int unsigned NUM_TAPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [NUM_TAPS-1:0]  tick,
  input  logic                 sel,
  input  logic [OFS_W-1:0]     ofs,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [BUS_DW-1:0]    wdata,
  output logic [BUS_DW-1:0]    rdata,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     cmp,
  output logic                 flag_match,
  output logic                 flag_wrap,
  output logic                 cnt_load,
  output logic                 pin,
  output logic                 irq
);
  localparam int unsigned SEL_W = $clog2(NUM_TAPS);

  logic [REG_W-1:0] ctrl_q, ctrl_d, mode_q, mode_d, outc_q, outc_d, ien_q, ien_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cmp_q, cmp_d;
  logic             fm_q, fm_d, fw_q, fw_d, arm_m_q, arm_m_d, arm_w_q, arm_w_d;
  logic             pin_q, pin_d;

  logic we_ctrl, we_mode, we_outc, we_ien, we_sts, we_cnt, we_cmp, rd_sts;
  logic [2:0] presc, clr_sel;
  logic tap_ok, cnt_en, hit, clr_hit, wrap, kill_m, kill_w;
  logic [1:0] init_new;
  pin_act_e act_now;

  // next-state logic
  always_comb begin
    we_ctrl = sel & wr & (ofs == OFS_CTRL);
    we_mode = sel & wr & (ofs == OFS_MODE);
    we_outc = sel & wr & (ofs == OFS_OUTC);
    we_ien  = sel & wr & (ofs == OFS_IEN);
    we_sts  = sel & wr & (ofs == OFS_STS);
    we_cnt  = sel & wr & (ofs == OFS_CNT);
    we_cmp  = sel & wr & (ofs == OFS_CMP);
    rd_sts  = sel & rd & (ofs == OFS_STS);

    presc   = ctrl_q[2:0];
    clr_sel = ctrl_q[7:5];
    tap_ok  = int'(presc) < NUM_TAPS;
    cnt_en  = run & (mode_q[3:0] == 4'd0) & tap_ok & tick[presc[SEL_W-1:0]];
    hit     = cnt_en & (cnt_q == cmp_q);
    clr_hit = hit & (clr_sel == CLR_ON_MATCH);
    wrap    = cnt_en & ~clr_hit & (cnt_q == '1);

    ctrl_d = we_ctrl ? wdata[REG_W-1:0] : ctrl_q;
    mode_d = we_mode ? wdata[REG_W-1:0] : mode_q;
    outc_d = we_outc ? wdata[REG_W-1:0] : outc_q;
    ien_d  = we_ien  ? wdata[REG_W-1:0] : ien_q;
    cmp_d  = we_cmp  ? wdata[CNT_W-1:0] : cmp_q;

    cnt_d = cnt_q;
    if (we_cnt)       cnt_d = wdata[CNT_W-1:0];
    else if (clr_hit) cnt_d = '0;
    else if (cnt_en)  cnt_d = cnt_q + CNT_W'(1);

    // flags: a new event wins, a zero write clears only when armed by a read
    kill_m  = we_sts & ~wdata[FLG_MATCH_BIT] & arm_m_q;
    kill_w  = we_sts & ~wdata[FLG_WRAP_BIT]  & arm_w_q;
    fm_d    = hit  | (fm_q & ~kill_m);
    fw_d    = wrap | (fw_q & ~kill_w);
    arm_m_d = ~hit  & fm_d & (arm_m_q | (rd_sts & fm_q));
    arm_w_d = ~wrap & fw_d & (arm_w_q | (rd_sts & fw_q));

    init_new = outc_init(wdata[3:0]);
    act_now  = outc_action(outc_q[3:0]);
    pin_d    = pin_q;
    if (we_outc) begin
      if (init_new[1]) pin_d = init_new[0];
    end else if (hit) begin
      case (act_now)
        PIN_LOW:  pin_d = 1'b0;
        PIN_HIGH: pin_d = 1'b1;
        PIN_FLIP: pin_d = ~pin_q;
        default:  pin_d = pin_q;
      endcase
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_CTRL: rdata[REG_W-1:0] = ctrl_q;
      OFS_MODE: rdata[REG_W-1:0] = mode_q;
      OFS_OUTC: rdata[REG_W-1:0] = outc_q;
      OFS_IEN:  rdata[REG_W-1:0] = ien_q;
      OFS_STS: begin
        rdata[FLG_MATCH_BIT] = fm_q;
        rdata[FLG_WRAP_BIT]  = fw_q;
      end
      OFS_CNT:  rdata = BUS_DW'(cnt_q);
      OFS_CMP:  rdata = BUS_DW'(cmp_q);
      default:  rdata = '0;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      outc_q  <= '0;
      ien_q   <= '0;
      cnt_q   <= '0;
      cmp_q   <= '0;
      fm_q    <= 1'b0;
      fw_q    <= 1'b0;
      arm_m_q <= 1'b0;
      arm_w_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      mode_q  <= mode_d;
      outc_q  <= outc_d;
      ien_q   <= ien_d;
      cnt_q   <= cnt_d;
      cmp_q   <= cmp_d;
      fm_q    <= fm_d;
      fw_q    <= fw_d;
      arm_m_q <= arm_m_d;
      arm_w_q <= arm_w_d;
      pin_q   <= pin_d;
    end
  end

  assign cnt        = cnt_q;
  assign cmp        = cmp_q;
  assign flag_match = fm_q;
  assign flag_wrap  = fw_q;
  assign cnt_load   = we_cnt;
  assign pin        = pin_q;
  assign irq        = (fm_q & ien_q[FLG_MATCH_BIT]) | (fw_q & ien_q[FLG_WRAP_BIT]);
endmodule

// File: rtl/cmt_unit.sv
module cmt_unit
  import cmt_pkg::*;
#(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned NUM_TAPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic [NUM_CH-1:0] tmr_out,
  output logic [NUM_CH-1:0] tmr_irq
);
  logic                rst_core_n;
  logic [NUM_TAPS-1:0] tick;
  logic [NUM_CH-1:0]   start_q, start_d;
  logic                start_hit;

  logic [NUM_CH-1:0]               ch_sel;
  logic [NUM_CH-1:0][BUS_DW-1:0]   ch_rdata;
  logic [NUM_CH-1:0][BUS_DW-1:0]   ch_cnt;
  logic [NUM_CH-1:0][BUS_DW-1:0]   ch_cmp;
  logic [NUM_CH-1:0]               ch_flag_m, ch_flag_w, ch_cnt_we;

  cmt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cmt_prescale #(.NUM_TAPS(NUM_TAPS)) u_pre (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (tick)
  );

  always_comb begin
    start_hit = (bus_addr == START_ADDR);
    start_d   = (start_hit & bus_wr) ? bus_wdata[NUM_CH-1:0] : start_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) start_q <= '0;
    else             start_q <= start_d;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [BUS_AW-1:0] BASE = chan_base(i);

    assign ch_sel[i] = (bus_addr[BUS_AW-1:OFS_W] == BASE[BUS_AW-1:OFS_W]);

    cmt_channel #(.CNT_W(BUS_DW), .NUM_TAPS(NUM_TAPS)) u_ch (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .run        (start_q[i]),
      .tick       (tick),
      .sel        (ch_sel[i]),
      .ofs        (bus_addr[OFS_W-1:0]),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .wdata      (bus_wdata),
      .rdata      (ch_rdata[i]),
      .cnt        (ch_cnt[i]),
      .cmp        (ch_cmp[i]),
      .flag_match (ch_flag_m[i]),
      .flag_wrap  (ch_flag_w[i]),
      .cnt_load   (ch_cnt_we[i]),
      .pin        (tmr_out[i]),
      .irq        (tmr_irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (start_hit) begin
      bus_rdata = BUS_DW'(start_q);
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_sel[c]) bus_rdata = bus_rdata | ch_rdata[c];
      end
    end
  end
endmodule

// File: rtl/cmt_unit_chk.sv
module cmt_unit_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wr,
  input logic [NUM_CH-1:0]             tmr_out,
  input logic [NUM_CH-1:0]             tmr_irq,
  input logic [NUM_CH-1:0]             start_q,
  input logic [NUM_CH-1:0]             ch_flag_m,
  input logic [NUM_CH-1:0]             ch_flag_w,
  input logic [NUM_CH-1:0]             ch_cnt_we,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_cmp
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (tmr_irq == '0 && tmr_out == '0))
    else $error("outputs active when reset released");

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_q[c] && !ch_cnt_we[c]) |=> $stable(ch_cnt[c]))
      else $error("stopped counter moved");

    assert_match_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_flag_m[c]) |-> $past(start_q[c] && ch_cnt[c] == ch_cmp[c]))
      else $error("match flag without equal counter");

    assert_wrap_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_flag_w[c]) |-> $past(&ch_cnt[c]))
      else $error("wrap flag without all-ones counter");

    assert_flag_cleared_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_flag_m[c]) |-> $past(bus_wr))
      else $error("match flag dropped without a bus write");
  end
endmodule

bind cmt_unit cmt_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(cmt_pkg::BUS_DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .tmr_out   (tmr_out),
  .tmr_irq   (tmr_irq),
  .start_q   (start_q),
  .ch_flag_m (ch_flag_m),
  .ch_flag_w (ch_flag_w),
  .ch_cnt_we (ch_cnt_we),
  .ch_cnt    (ch_cnt),
  .ch_cmp    (ch_cmp)
);

// File: tb/sim_cmt_unit.sv
`timescale 1ns/1ps
module sim_cmt_unit;
  localparam logic [9:0] ST = 10'h280;
  localparam logic [9:0] C0 = 10'h300;
  localparam logic [9:0] C1 = 10'h380;
  localparam logic [9:0] C2 = 10'h000;

  logic        clk, rst_n, bus_wr, bus_rd;
  logic [9:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [2:0]  tmr_out, tmr_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] mon_exp;
  string       mon_tag;

  cmt_unit #(.NUM_CH(3)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_out(tmr_out), .tmr_irq(tmr_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read strobe, mid-cycle
  always @(negedge clk) begin
    if (bus_rd === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 unexpected read: actual %h expected none", bus_rdata);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        chk(mon_tag, bus_rdata, mon_exp);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected value, then issues the read
  task automatic rd(input logic [9:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  // runs the channels in mask for exactly n clock edges
  task automatic run(input logic [2:0] mask, input int n);
    wr(ST, {13'd0, mask});
    repeat (n - 2) @(posedge clk);
    wr(ST, 16'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(C0 + 0, 16'h0000, "R1 ctrl");
    rd(C0 + 5, 16'h0000, "R1 status");
    rd(C1 + 6, 16'h0000, "R1 counter");
    rd(C2 + 8, 16'h0000, "R1 compare");
    rd(ST,     16'h0000, "R1 run");
    chk("R1 pins", {13'd0, tmr_out}, 16'h0);
    chk("R1 irq",  {13'd0, tmr_irq}, 16'h0);

    // R10 address map
    wr(C1 + 8, 16'h1234); rd(C1 + 8, 16'h1234, "R10 compare");
    wr(C2 + 6, 16'h00AB); rd(C2 + 6, 16'h00AB, "R10 counter");
    wr(C0 + 0, 16'h00A5); rd(C0 + 0, 16'h00A5, "R10 ctrl"); wr(C0 + 0, 16'h0);
    wr(C0 + 4, 16'h0011); rd(C0 + 4, 16'h0011, "R10 ien");  wr(C0 + 4, 16'h0);
    wr(C0 + 1, 16'h0007); rd(C0 + 1, 16'h0007, "R10 mode"); wr(C0 + 1, 16'h0);
    rd(C0 + 12, 16'h0000, "R10 unmapped");

    // R4 periodic operation on channel 0
    wr(C0 + 0, 16'h0020); wr(C0 + 8, 16'd4); wr(C0 + 6, 16'd0);
    wr(C0 + 4, 16'h0001); wr(C0 + 2, 16'h0003);
    chk("R8 toggle code loads 0", {15'd0, tmr_out[0]}, 16'd0);
    run(3'b001, 7);
    chk("R8 toggled once", {15'd0, tmr_out[0]}, 16'd1);
    chk("R9 match irq",    {15'd0, tmr_irq[0]}, 16'd1);
    rd(C0 + 6, 16'd2, "R4 count after 7 ticks");
    // R7 clearing protocol
    wr(C0 + 5, 16'h0000);
    rd(C0 + 5, 16'h0001, "R7 blind zero write ignored");
    wr(C0 + 5, 16'h00FF);
    rd(C0 + 5, 16'h0001, "R7 write of one ignored");
    wr(C0 + 5, 16'h0000);
    rd(C0 + 5, 16'h0000, "R7 read then zero clears");
    chk("R9 irq drops", {15'd0, tmr_irq[0]}, 16'd0);
    wr(C0 + 6, 16'd0);
    run(3'b001, 11);
    rd(C0 + 6, 16'd1, "R4 count after 11 ticks");
    chk("R8 toggled twice", {15'd0, tmr_out[0]}, 16'd1);
    rd(C0 + 5, 16'h0001, "R4 flag set");
    wr(C0 + 5, 16'h0000);

    // R3 prescaler on channel 1
    wr(C1 + 8, 16'hFFFF);
    wr(C1 + 0, 16'h0001); wr(C1 + 6, 16'd0); run(3'b010, 40);
    rd(C1 + 6, 16'd10, "R3 divide by 4");
    wr(C1 + 0, 16'h0002); wr(C1 + 6, 16'd0); run(3'b010, 64);
    rd(C1 + 6, 16'd4, "R3 divide by 16");
    wr(C1 + 0, 16'h0003); wr(C1 + 6, 16'd0); run(3'b010, 128);
    rd(C1 + 6, 16'd2, "R3 divide by 64");
    wr(C1 + 0, 16'h0005); wr(C1 + 6, 16'd0); run(3'b010, 20);
    rd(C1 + 6, 16'd0, "R3 reserved code stops");

    // R6 mode
    wr(C1 + 0, 16'h0000); wr(C1 + 1, 16'h0002); wr(C1 + 6, 16'd0); run(3'b010, 10);
    rd(C1 + 6, 16'd0, "R6 non-normal mode holds");
    wr(C1 + 1, 16'h0000); run(3'b010, 10);
    rd(C1 + 6, 16'd10, "R6 normal mode counts");

    // R11 edge field
    wr(C1 + 0, 16'h0010); wr(C1 + 6, 16'd0); run(3'b010, 10);
    rd(C1 + 6, 16'd10, "R11 both-edge code");
    rd(C1 + 0, 16'h0010, "R11 field stored");
    wr(C1 + 0, 16'h0008); wr(C1 + 6, 16'd0); run(3'b010, 10);
    rd(C1 + 6, 16'd10, "R11 falling code");

    // R2 independent run bits
    wr(C0 + 0, 16'h0000); wr(C0 + 8, 16'hFFFF); wr(C0 + 6, 16'd5);
    wr(C1 + 0, 16'h0000); wr(C1 + 6, 16'd0);
    run(3'b010, 12);
    rd(C0 + 6, 16'd5,  "R2 stopped channel holds");
    rd(C1 + 6, 16'd12, "R2 running channel counts");
    run(3'b011, 6);
    rd(C0 + 6, 16'd11, "R2 both run ch0");
    rd(C1 + 6, 16'd18, "R2 both run ch1");

    // R5 overflow on channel 2
    wr(C2 + 0, 16'h0000); wr(C2 + 8, 16'h1000); wr(C2 + 6, 16'hFFFE); wr(C2 + 4, 16'h0010);
    run(3'b100, 2);
    rd(C2 + 6, 16'd0, "R5 wrapped to zero");
    chk("R9 overflow irq", {15'd0, tmr_irq[2]}, 16'd1);
    rd(C2 + 5, 16'h0010, "R5 wrap flag");
    wr(C2 + 5, 16'h0000);
    rd(C2 + 5, 16'h0000, "R7 wrap flag cleared");
    chk("R9 overflow irq drops", {15'd0, tmr_irq[2]}, 16'd0);
    wr(C2 + 0, 16'h0020); wr(C2 + 8, 16'hFFFF); wr(C2 + 6, 16'hFFFE); wr(C2 + 4, 16'h0011);
    run(3'b100, 2);
    rd(C2 + 6, 16'd0, "R5 match return to zero");
    rd(C2 + 5, 16'h0001, "R5 no wrap flag on match clear");

    // R8 pin codes on channel 1
    wr(C1 + 2, 16'h0005); chk("R8 code 5 loads 1", {15'd0, tmr_out[1]}, 16'd1);
    wr(C1 + 2, 16'h0001); chk("R8 code 1 loads 0", {15'd0, tmr_out[1]}, 16'd0);
    wr(C1 + 2, 16'h0006); chk("R8 code 6 loads 1", {15'd0, tmr_out[1]}, 16'd1);
    wr(C1 + 2, 16'h0000); chk("R8 code 0 keeps",   {15'd0, tmr_out[1]}, 16'd1);
    wr(C1 + 0, 16'h0020); wr(C1 + 8, 16'd2); wr(C1 + 6, 16'd0);
    wr(C1 + 2, 16'h0002); chk("R8 code 2 loads 0", {15'd0, tmr_out[1]}, 16'd0);
    run(3'b010, 4);
    chk("R8 set on match", {15'd0, tmr_out[1]}, 16'd1);
    wr(C1 + 2, 16'h0005); wr(C1 + 6, 16'd0);
    run(3'b010, 4);
    chk("R8 clear on match", {15'd0, tmr_out[1]}, 16'd0);
    wr(C1 + 2, 16'h0050); chk("R8 upper field no effect", {15'd0, tmr_out[1]}, 16'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule